// File: doc/BRIEF.md
# Bidirectional Cascadable Column Data Sampler

This block collects display pixel data for one column driver of a display panel. Each clock carries an 18-bit word made of three 6-bit subpixel values. A one-hot group pointer directs each word into a three-column slot of a wide column register. A start pulse arms the pointer, and the pointer then walks across the column groups, upward or downward as the direction input selects. When the walk ends or a latch strobe arrives, the pointer stops. Each subpixel can be bit-inverted as it is stored.

Several drivers can be chained. The start pin on one side takes the incoming start pulse, and the pin on the other side sends a one-cycle pulse to the next driver. That pulse is timed so that the next driver stores its first word on the clock right after this driver stores its last one. A mode input selects between the full column count and a reduced count. In the reduced count a band of three groups in the middle of the register is skipped. Each bidirectional start pin is modelled as an input, an output and an output enable.

Top module: `column_sampler`

## Requirements
- R1: While reset is asserted and after it is released, every bit of the column register is 0, no slot is written until a start pulse arrives, and both start outputs are low.
- R2: With `dir_up_i` high, a pulse on `start_r_i` arms the scan. The clock edge that samples the pulse stores nothing. The k-th word after it goes to group k-1, counting upward. Subpixel j, at bits [6j+5:6j] of `pix_i`, goes to column 3g+j+1 of group g. Column c (1-based) occupies bits [6(c-1)+5:6(c-1)] of `col_data_o`.
- R3: With `dir_up_i` low, a pulse on `start_l_i` arms the scan. The first word goes to group 102 (columns 307..309), and later words go to groups counting downward.
- R4: With `narrow_i` low (full mode), all 103 groups are filled, so one scan takes 103 words.
- R5: With `narrow_i` high (reduced mode), groups 50..52 (columns 151..159) are skipped and keep their contents. One scan takes 100 words.
- R6: The cascade pulse leaves on `start_l_o` when the direction is upward and on `start_r_o` when it is downward. It is high for exactly one cycle: the cycle in which the final word of the scan is on `pix_i`. The output enable of the sending pin is high and the enable of the receiving pin is low.
- R7: With `invert_i` high, every 6-bit subpixel is stored bitwise inverted. With it low, subpixels are stored unchanged.
- R8: A clock edge with `strobe_i` high and no start pulse stores nothing and stops the scan. Later words leave the register unchanged until a new start pulse arrives.
- R9: A start pulse during an active scan restarts the walk at the first group for the current direction. The full word count and the cascade timing are measured from the new pulse.
- R10: After the final word of a scan, further words leave the register unchanged and no further cascade pulse is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; data is stored on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_i | input | 18 | Three 6-bit subpixel values, subpixel 0 in the low bits |
| dir_up_i | input | 1 | 1: fill upward from the right pin; 0: fill downward from the left pin |
| narrow_i | input | 1 | 1: reduced column count with the middle band skipped (tie high when unused) |
| invert_i | input | 1 | 1: store subpixels inverted |
| strobe_i | input | 1 | Latch strobe; clears the pointer |
| start_r_i | input | 1 | Right-side start pin, input path |
| start_r_o | output | 1 | Right-side start pin, output path (cascade when downward) |
| start_r_oe | output | 1 | Right-side start pin output enable |
| start_l_i | input | 1 | Left-side start pin, input path |
| start_l_o | output | 1 | Left-side start pin, output path (cascade when upward) |
| start_l_oe | output | 1 | Left-side start pin output enable |
| col_data_o | output | 1854 | Flat column register, 309 columns of 6 bits |

## Verification
The assertions check the pointer's structure on every cycle. They cover the single-hot pointer, the clearing by the strobe, the restart position, the fact that a reduced-mode scan never enters the skipped band, the one-cycle cascade width, and that each enabled slot takes the word presented to it. The bench's scenarios are needed to show the column placement and the fill order in both directions, the skipped band keeping old data, the inversion, and the cascade pulse landing on exactly the final word. They also show that writes stop after a strobe and after the end of a scan. These outcomes depend on counting whole scans and comparing the full register.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned SUB_BITS = 6;
  localparam int unsigned SUB_CNT  = 3;
  localparam int unsigned WORD_BITS = SUB_BITS * SUB_CNT;
endpackage

// File: rtl/cs_condition.sv
module cs_condition
  import cs_pkg::*;
(
  input  logic [WORD_BITS-1:0] raw_i,
  input  logic                 invert_i,
  output logic [WORD_BITS-1:0] word_o
);
  // each subpixel is flipped on its own field so the slicing stays explicit
  for (genvar s = 0; s < SUB_CNT; s++) begin : g_sub
    assign word_o[s*SUB_BITS +: SUB_BITS] =
      raw_i[s*SUB_BITS +: SUB_BITS] ^ {SUB_BITS{invert_i}};
  end
endmodule

// File: rtl/cs_pointer.sv
module cs_pointer #(
  parameter int unsigned GROUPS  = 103,
  parameter int unsigned SKIP_LO = 50,
  parameter int unsigned SKIP_HI = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              strobe_i,
  input  logic              dir_up_i,
  input  logic              short_i,
  output logic [GROUPS-1:0] ptr_o,
  output logic              casc_o
);
  localparam logic [GROUPS-1:0] FIRST_UP = {{(GROUPS-1){1'b0}}, 1'b1};
  localparam logic [GROUPS-1:0] FIRST_DN = {1'b1, {(GROUPS-1){1'b0}}};

  logic [GROUPS-1:0] ptr_q, ptr_d, step_vec, band_mask;
  logic              casc_q, casc_d, ptr_en;

  for (genvar g = 0; g < GROUPS; g++) begin : g_step
    localparam bit IN_BAND = (g >= SKIP_LO) && (g <= SKIP_HI);
    logic from_lo, from_hi, jump_up, jump_dn, walk;
    if (g == 0) begin : g_lo0
      assign from_lo = 1'b0;
    end else begin : g_lon
      assign from_lo = ptr_q[g-1];
    end
    if (g == GROUPS-1) begin : g_hi0
      assign from_hi = 1'b0;
    end else begin : g_hin
      assign from_hi = ptr_q[g+1];
    end
    if (g == SKIP_HI+1) begin : g_jup
      assign jump_up = ptr_q[SKIP_LO-1];
    end else begin : g_njup
      assign jump_up = 1'b0;
    end
    if (g == SKIP_LO-1) begin : g_jdn
      assign jump_dn = ptr_q[SKIP_HI+1];
    end else begin : g_njdn
      assign jump_dn = 1'b0;
    end
    assign walk = dir_up_i ? (from_lo | (short_i & jump_up))
                           : (from_hi | (short_i & jump_dn));
    assign band_mask[g] = IN_BAND;
    if (IN_BAND) begin : g_band
      assign step_vec[g] = walk & ~short_i;
    end else begin : g_open
      assign step_vec[g] = walk;
    end
  end

  always_comb begin
    if (start_i)       ptr_d = dir_up_i ? FIRST_UP : FIRST_DN;
    else if (strobe_i) ptr_d = '0;
    else               ptr_d = step_vec;
    ptr_en = start_i | strobe_i | (|ptr_q);
    casc_d = ~start_i & ~strobe_i &
             (dir_up_i ? ptr_q[GROUPS-2] : ptr_q[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      casc_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      casc_q <= casc_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign casc_o = casc_q;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q));
  p_strobe_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !start_i) |=> (ptr_q == '0));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ptr_q == ($past(dir_up_i) ? FIRST_UP : FIRST_DN)));
  p_band_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_i && ((ptr_q & band_mask) == '0)) |=> ((ptr_q & band_mask) == '0));
  p_cascade_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |=> !casc_q);
endmodule

// File: rtl/cs_colreg.sv
module cs_colreg
  import cs_pkg::*;
#(
  parameter int unsigned GROUPS = 103
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [GROUPS-1:0]           we_i,
  input  logic [WORD_BITS-1:0]        word_i,
  output logic [GROUPS*WORD_BITS-1:0] data_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    logic [WORD_BITS-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (we_i[g]) slot_q <= word_i;
    end
    assign data_o[g*WORD_BITS +: WORD_BITS] = slot_q;

    p_store_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we_i[g] |=> (slot_q == $past(word_i)));
  end
endmodule

// File: rtl/column_sampler.sv
module column_sampler
  import cs_pkg::*;
#(
  parameter int unsigned GROUPS  = 103,
  parameter int unsigned SKIP_LO = 50,
  parameter int unsigned SKIP_HI = 52,
  localparam int unsigned COLS   = GROUPS * SUB_CNT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WORD_BITS-1:0]     pix_i,
  input  logic                     dir_up_i,
  input  logic                     narrow_i,
  input  logic                     invert_i,
  input  logic                     strobe_i,
  input  logic                     start_r_i,
  output logic                     start_r_o,
  output logic                     start_r_oe,
  input  logic                     start_l_i,
  output logic                     start_l_o,
  output logic                     start_l_oe,
  output logic [COLS*SUB_BITS-1:0] col_data_o
);
  logic [1:0]           rsync_q;
  logic                 rst_n_s;
  logic                 start_in, casc;
  logic [GROUPS-1:0]    ptr, we;
  logic [WORD_BITS-1:0] word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  assign start_in = dir_up_i ? start_r_i : start_l_i;

  cs_pointer #(.GROUPS(GROUPS), .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_in), .strobe_i(strobe_i),
    .dir_up_i(dir_up_i), .short_i(narrow_i), .ptr_o(ptr), .casc_o(casc)
  );

  cs_condition u_cond (.raw_i(pix_i), .invert_i(invert_i), .word_o(word));

  // start and strobe edges never store data
  assign we = ptr & {GROUPS{~strobe_i & ~start_in}};

  cs_colreg #(.GROUPS(GROUPS)) u_reg (
    .clk(clk), .rst_n(rst_n_s), .we_i(we), .word_i(word), .data_o(col_data_o)
  );

  assign start_l_o  = casc & dir_up_i;
  assign start_r_o  = casc & ~dir_up_i;
  assign start_l_oe = dir_up_i;
  assign start_r_oe = ~dir_up_i;

  p_idle_out_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ptr == '0 && !start_in) |=> !(start_l_o || start_r_o));
endmodule

// File: tb/column_sampler_bench.sv
module column_sampler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GROUPS = 103;
  localparam int SKIP_LO = 50;
  localparam int SKIP_HI = 52;
  localparam int COLS = GROUPS * 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [17:0] pix_i;
  logic dir_up_i, narrow_i, invert_i, strobe_i, start_r_i, start_l_i;
  logic start_r_o, start_r_oe, start_l_o, start_l_oe;
  logic [COLS*6-1:0] col_data_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_col [0:COLS-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  column_sampler u_column_sampler (
    .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .dir_up_i(dir_up_i),
    .narrow_i(narrow_i), .invert_i(invert_i), .strobe_i(strobe_i),
    .start_r_i(start_r_i), .start_r_o(start_r_o), .start_r_oe(start_r_oe),
    .start_l_i(start_l_i), .start_l_o(start_l_o), .start_l_oe(start_l_oe),
    .col_data_o(col_data_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int seq_grp(int i, bit up, bit sh);
    int n = 0;
    for (int s = 0; s < GROUPS; s++) begin
      int g = up ? s : GROUPS - 1 - s;
      if (sh && g >= SKIP_LO && g <= SKIP_HI) continue;
      if (n == i) return g;
      n++;
    end
    return -1;
  endfunction

  function automatic logic [17:0] mk_word(int i, int seed);
    logic [5:0] a, b, c;
    a = 6'((i * 7 + seed) & 63);
    b = 6'((i * 3 + seed + 1) & 63);
    c = 6'((i * 5 + seed + 2) & 63);
    return {c, b, a};
  endfunction

  task automatic check_cols(input string req, input string what);
    int bad = 0, first = -1;
    for (int c = 0; c < COLS; c++) begin
      if (col_data_o[c*6 +: 6] !== exp_col[c]) begin
        bad++;
        if (first < 0) first = c;
      end
    end
    if (first < 0) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, {what, " column value"},
               int'(col_data_o[first*6 +: 6]), int'(exp_col[first]));
  endtask

  task automatic begin_scan(input bit up, input bit sh, input bit inv);
    dir_up_i = up; narrow_i = sh; invert_i = inv;
    if (up) start_r_i = 1'b1; else start_l_i = 1'b1;
    pix_i = 18'h3FFFF;
    @(negedge clk);
    start_r_i = 1'b0; start_l_i = 1'b0;
  endtask

  task automatic push(input logic [17:0] w, input int g, input bit inv);
    pix_i = w;
    if (g >= 0)
      for (int k = 0; k < 3; k++)
        exp_col[g*3 + k] = inv ? ~w[k*6 +: 6] : w[k*6 +: 6];
    @(negedge clk);
  endtask

  // drives nwords words, checking the cascade pulse before each one
  task automatic run_words(input bit up, input bit sh, input bit inv,
                           input int nwords, input int seed, input string req);
    int total = sh ? GROUPS - (SKIP_HI - SKIP_LO + 1) : GROUPS;
    int bad = 0, first = -1;
    logic c;
    for (int i = 0; i < nwords; i++) begin
      c = up ? start_l_o : start_r_o;
      if (c !== (i == total - 1)) begin
        bad++;
        if (first < 0) first = i;
      end
      push(mk_word(i, seed), i < total ? seq_grp(i, up, sh) : -1, inv);
    end
    check(bad == 0, req, "cascade pulse on final word only (first bad index)",
          first, total - 1);
  endtask

  task automatic t_reset;
    check_cols("R1", "register cleared by reset");
    check(start_l_o === 1'b0 && start_r_o === 1'b0, "R1", "start outputs low",
          int'({start_l_o, start_r_o}), 0);
    pix_i = 18'h15A5A;
    repeat (3) @(negedge clk);
    check_cols("R1", "no write before start");
  endtask

  task automatic t_up_full;
    begin_scan(1'b1, 1'b0, 1'b0);
    check(start_l_oe === 1'b1 && start_r_oe === 1'b0, "R6", "pin enables upward",
          int'({start_l_oe, start_r_oe}), 2);
    run_words(1'b1, 1'b0, 1'b0, 106, 4, "R4 R6");
    check_cols("R2", "upward full fill placement");
    check_cols("R10", "words after final group ignored");
  endtask

  task automatic t_down_narrow_inv;
    begin_scan(1'b0, 1'b1, 1'b1);
    check(start_r_oe === 1'b1 && start_l_oe === 1'b0, "R6", "pin enables downward",
          int'({start_r_oe, start_l_oe}), 2);
    run_words(1'b0, 1'b1, 1'b1, 101, 19, "R5 R6");
    check_cols("R3", "downward fill order");
    check_cols("R5", "band 151..159 retained");
    check_cols("R7", "inverted storage");
  endtask

  task automatic t_strobe;
    begin_scan(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) push(mk_word(i, 33), seq_grp(i, 1'b1, 1'b0), 1'b0);
    strobe_i = 1'b1;
    push(18'h2AAAA, -1, 1'b0);
    strobe_i = 1'b0;
    for (int i = 0; i < 8; i++) push(mk_word(i, 50), -1, 1'b0);
    check_cols("R8", "strobe stops writes");
    check(start_l_o === 1'b0, "R8", "no cascade after strobe", int'(start_l_o), 0);
  endtask

  task automatic t_restart;
    begin_scan(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) push(mk_word(i, 9), seq_grp(i, 1'b1, 1'b1), 1'b0);
    begin_scan(1'b1, 1'b1, 1'b0);
    run_words(1'b1, 1'b1, 1'b0, 101, 27, "R9");
    check_cols("R9", "restart fill from group 0");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int c = 0; c < COLS; c++) exp_col[c] = '0;
    rst_n = 1'b0; pix_i = '0; dir_up_i = 1'b1; narrow_i = 1'b1;
    invert_i = 1'b0; strobe_i = 1'b0; start_r_i = 1'b0; start_l_i = 1'b0;
    repeat (3) @(negedge clk);
    check_cols("R1", "register zero during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_up_full();
    t_down_narrow_inv();
    t_strobe();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule